// File: doc/BRIEF.md
# Bus-Width Matching Port with Selectable Lane Order

This block sits between a pair of 36-bit FIFO word interfaces and one external data port whose width is 36, 18 or 9 bits. In the outbound direction it takes one 36-bit word from the outbound FIFO and hands it to the port as one, two or four transfers. In the inbound direction it collects one, two or four port transfers into one 36-bit word and hands that word to the inbound FIFO. The FIFO memories and their flags are outside the block. The FIFOs only ever see whole 36-bit words.

The port width and the lane order are sampled while master reset is held. After that they stay fixed, whatever the configuration pins do. For the 18-bit and 9-bit widths the lane order is selectable. Big-endian moves the most significant part of the word first. Little-endian moves the least significant part first. A synchronous partial reset throws away any partly sent or partly assembled word and returns both lane counters to the start. It keeps the configuration.

All four data paths use valid/ready handshakes. A transfer happens on a rising edge where valid and ready are both high. A source that sees ready low must hold its data and valid until it is accepted. This block does so on both of its output streams. It drops ready on the FIFO read side while it still holds portions of the current word. It drops ready on the port input side while an assembled word is waiting and the inbound FIFO does not accept it. When the current word's last portion leaves in the same cycle, the block takes the next word without a bubble. When a waiting word is pushed in the same cycle, the block accepts the next portion without a bubble.

Top module: `busmatch_port`

## Requirements
- R1: Width code `cfg_size` (00 = 36-bit, 01 = 18-bit, 10 = 9-bit, 11 = treated as 36-bit) and `cfg_big_end` are sampled on every clock edge while `rst_n` is low. After `rst_n` rises, changes on these pins have no effect on the block's behaviour.
- R2: In 36-bit mode every word passes whole, as exactly one transfer in each direction.
- R3: In 18-bit mode a word is carried as two transfers on port bits 17:0. Big-endian moves word bits 35:18 first and then 17:0. Little-endian moves 17:0 first and then 35:18.
- R4: In 9-bit mode a word is carried as four transfers on port bits 8:0. Big-endian moves word bits 35:27, 26:18, 17:9 and 8:0 in that order. Little-endian moves them in the reverse order.
- R5: In 18-bit and 9-bit modes the unused upper bits of `port_out_data` are driven to zero. The unused upper bits of `port_in_data` have no effect on the assembled word.
- R6: A word is taken from the outbound FIFO only when no portion of an earlier word is still waiting to leave, counting a last portion that leaves in the same cycle as already gone. The first portion of a taken word is offered on the next cycle. A continuous stream with all ready signals high therefore runs without gaps.
- R7: An assembled word is offered to the inbound FIFO on the cycle after its last portion is accepted, and never before that portion is accepted.
- R8: While `port_out_valid` or `fifo_wr_valid` is high and its ready input is low, that valid output and its data stay unchanged on the next cycle. The only exception is a partial reset.
- R9: While `part_rst` is high, all four handshakes are blocked. After it, no held or partly assembled word remains and both lane counters restart at the first portion. The configuration sampled at master reset is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Master reset, active low; configuration is sampled while low |
| part_rst | input | 1 | Synchronous partial reset, active high |
| cfg_size | input | 2 | Port width code, sampled during master reset |
| cfg_big_end | input | 1 | 1 = big-endian lane order, sampled during master reset |
| fifo_rd_data | input | 36 | Word offered by the outbound FIFO |
| fifo_rd_valid | input | 1 | Outbound FIFO has a word |
| fifo_rd_ready | output | 1 | Block takes the offered word (pop) |
| port_out_data | output | 36 | Port output transfer, unused upper bits zero |
| port_out_valid | output | 1 | A port output transfer is offered |
| port_out_ready | input | 1 | Port sink accepts the transfer |
| port_in_data | input | 36 | Port input transfer |
| port_in_valid | input | 1 | A port input transfer is offered |
| port_in_ready | output | 1 | Block accepts the port input transfer |
| fifo_wr_data | output | 36 | Assembled word for the inbound FIFO |
| fifo_wr_valid | output | 1 | An assembled word is offered (push) |
| fifo_wr_ready | input | 1 | Inbound FIFO accepts the word |

## Verification
Two pairs of events can fall on the same edge. On the outbound side, the last portion of a word can leave on the same edge that the next word is taken from the FIFO. On the inbound side, an assembled word can be pushed on the same edge that the first portion of the next word is accepted. Random valid and ready patterns make these coincide often, and runs with every handshake held high force them on every word boundary. Each case is judged in three ways: the order of the port transfers, the words the FIFO side receives, and the total cycle count of a gap-free stream against one transfer per cycle.

// File: rtl/busmatch_pkg.sv
package busmatch_pkg;

  // Port width codes sampled at master reset
  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_HALF = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_RSVD = 2'b11
  } bm_size_e;

  typedef struct packed {
    bm_size_e size;
    logic     big_end;
  } bm_cfg_t;

endpackage

// File: rtl/bm_cfg_latch.sv
module bm_cfg_latch
  import busmatch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_size,
  input  logic       cfg_big_end,
  output bm_cfg_t    cfg_q
);

  bm_size_e size_map;

  always_comb begin
    case (cfg_size)
      2'b01:   size_map = SZ_HALF;
      2'b10:   size_map = SZ_BYTE;
      default: size_map = SZ_LONG;
    endcase
  end

  // Sampled on every edge while master reset is held, frozen afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.size    <= size_map;
      cfg_q.big_end <= cfg_big_end;
    end
  end

  // R1
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cfg_q));

endmodule

// File: rtl/bm_unpack.sv
module bm_unpack
  import busmatch_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     part_rst,
  input  bm_cfg_t                  cfg,
  input  logic [LANE_W*LANES-1:0]  fifo_rd_data,
  input  logic                     fifo_rd_valid,
  output logic                     fifo_rd_ready,
  output logic [LANE_W*LANES-1:0]  port_out_data,
  output logic                     port_out_valid,
  input  logic                     port_out_ready
);

  localparam int WORD_W = LANE_W * LANES;
  localparam int CNT_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int HALF   = LANES / 2;

  logic [WORD_W-1:0] word_q;
  logic              held_q;
  logic [CNT_W-1:0]  step_q;
  logic [CNT_W-1:0]  last_idx;
  logic [CNT_W-1:0]  chunk;
  logic              is_last;
  logic              out_hs;
  logic              pop;

  always_comb begin
    case (cfg.size)
      SZ_HALF: last_idx = CNT_W'(HALF - 1);
      SZ_BYTE: last_idx = CNT_W'(LANES - 1);
      default: last_idx = '0;
    endcase
  end

  assign chunk          = cfg.big_end ? (last_idx - step_q) : step_q;
  assign is_last        = (step_q == last_idx);
  assign port_out_valid = held_q && !part_rst;
  assign out_hs         = port_out_valid && port_out_ready;
  assign fifo_rd_ready  = !part_rst && (!held_q || (port_out_ready && is_last));
  assign pop            = fifo_rd_valid && fifo_rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      step_q <= '0;
      word_q <= '0;
    end else if (part_rst) begin
      held_q <= 1'b0;
      step_q <= '0;
    end else begin
      if (out_hs) step_q <= is_last ? '0 : step_q + 1'b1;
      if (pop) begin
        word_q <= fifo_rd_data;
        held_q <= 1'b1;
      end else if (out_hs && is_last) begin
        held_q <= 1'b0;
      end
    end
  end

  // One output lane per generate slice
  for (genvar j = 0; j < LANES; j++) begin : g_olane
    logic [CNT_W-1:0] sel;
    always_comb begin
      sel = '0;
      port_out_data[j*LANE_W +: LANE_W] = '0;
      case (cfg.size)
        SZ_HALF: begin
          sel = CNT_W'(chunk * HALF + j);
          if (j < HALF) port_out_data[j*LANE_W +: LANE_W] = word_q[sel*LANE_W +: LANE_W];
        end
        SZ_BYTE: begin
          sel = chunk;
          if (j == 0) port_out_data[j*LANE_W +: LANE_W] = word_q[sel*LANE_W +: LANE_W];
        end
        default: port_out_data[j*LANE_W +: LANE_W] = word_q[j*LANE_W +: LANE_W];
      endcase
    end
  end

  // R6
  pop_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd_valid && fifo_rd_ready) |=> (held_q && step_q == '0));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_out_valid && !port_out_ready) |=>
      (part_rst || (port_out_valid && $stable(port_out_data))));

  // R9
  flush_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    part_rst |=> (!held_q && step_q == '0));

endmodule

// File: rtl/bm_pack.sv
module bm_pack
  import busmatch_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     part_rst,
  input  bm_cfg_t                  cfg,
  input  logic [LANE_W*LANES-1:0]  port_in_data,
  input  logic                     port_in_valid,
  output logic                     port_in_ready,
  output logic [LANE_W*LANES-1:0]  fifo_wr_data,
  output logic                     fifo_wr_valid,
  input  logic                     fifo_wr_ready
);

  localparam int CNT_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int HALF  = LANES / 2;

  logic             full_q;
  logic [CNT_W-1:0] step_q;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] chunk;
  logic             is_last;
  logic             in_hs;
  logic             push;

  always_comb begin
    case (cfg.size)
      SZ_HALF: last_idx = CNT_W'(HALF - 1);
      SZ_BYTE: last_idx = CNT_W'(LANES - 1);
      default: last_idx = '0;
    endcase
  end

  assign chunk         = cfg.big_end ? (last_idx - step_q) : step_q;
  assign is_last       = (step_q == last_idx);
  assign fifo_wr_valid = full_q && !part_rst;
  assign push          = fifo_wr_valid && fifo_wr_ready;
  assign port_in_ready = !part_rst && (!full_q || fifo_wr_ready);
  assign in_hs         = port_in_valid && port_in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      step_q <= '0;
    end else if (part_rst) begin
      full_q <= 1'b0;
      step_q <= '0;
    end else begin
      if (in_hs) step_q <= is_last ? '0 : step_q + 1'b1;
      if (in_hs && is_last) full_q <= 1'b1;
      else if (push)        full_q <= 1'b0;
    end
  end

  // Each word lane has its own write enable and source slice
  for (genvar l = 0; l < LANES; l++) begin : g_ilane
    logic              we;
    logic [LANE_W-1:0] din;
    logic [LANE_W-1:0] acc_q;

    always_comb begin
      case (cfg.size)
        SZ_HALF: begin
          we  = (chunk == CNT_W'(l / HALF));
          din = port_in_data[(l % HALF)*LANE_W +: LANE_W];
        end
        SZ_BYTE: begin
          we  = (chunk == CNT_W'(l));
          din = port_in_data[LANE_W-1:0];
        end
        default: begin
          we  = 1'b1;
          din = port_in_data[l*LANE_W +: LANE_W];
        end
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          acc_q <= '0;
      else if (in_hs && we) acc_q <= din;
    end

    assign fifo_wr_data[l*LANE_W +: LANE_W] = acc_q;
  end

  // R7
  push_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hs && is_last) |=> (fifo_wr_valid || part_rst));

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_valid && !fifo_wr_ready) |=>
      (part_rst || (fifo_wr_valid && $stable(fifo_wr_data))));

  // R9
  flush_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    part_rst |=> (!fifo_wr_valid && step_q == '0));

endmodule

// File: rtl/busmatch_port.sv
module busmatch_port
  import busmatch_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    part_rst,
  input  logic [1:0]              cfg_size,
  input  logic                    cfg_big_end,
  input  logic [LANE_W*LANES-1:0] fifo_rd_data,
  input  logic                    fifo_rd_valid,
  output logic                    fifo_rd_ready,
  output logic [LANE_W*LANES-1:0] port_out_data,
  output logic                    port_out_valid,
  input  logic                    port_out_ready,
  input  logic [LANE_W*LANES-1:0] port_in_data,
  input  logic                    port_in_valid,
  output logic                    port_in_ready,
  output logic [LANE_W*LANES-1:0] fifo_wr_data,
  output logic                    fifo_wr_valid,
  input  logic                    fifo_wr_ready
);

  bm_cfg_t cfg_q;

  bm_cfg_latch u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_size    (cfg_size),
    .cfg_big_end (cfg_big_end),
    .cfg_q       (cfg_q)
  );

  bm_unpack #(.LANE_W(LANE_W), .LANES(LANES)) u_unpack (
    .clk            (clk),
    .rst_n          (rst_n),
    .part_rst       (part_rst),
    .cfg            (cfg_q),
    .fifo_rd_data   (fifo_rd_data),
    .fifo_rd_valid  (fifo_rd_valid),
    .fifo_rd_ready  (fifo_rd_ready),
    .port_out_data  (port_out_data),
    .port_out_valid (port_out_valid),
    .port_out_ready (port_out_ready)
  );

  bm_pack #(.LANE_W(LANE_W), .LANES(LANES)) u_pack (
    .clk           (clk),
    .rst_n         (rst_n),
    .part_rst      (part_rst),
    .cfg           (cfg_q),
    .port_in_data  (port_in_data),
    .port_in_valid (port_in_valid),
    .port_in_ready (port_in_ready),
    .fifo_wr_data  (fifo_wr_data),
    .fifo_wr_valid (fifo_wr_valid),
    .fifo_wr_ready (fifo_wr_ready)
  );

endmodule

// File: tb/tb_busmatch_port.sv
module tb_busmatch_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        part_rst = 1'b0;
  logic [1:0]  cfg_size = 2'b00;
  logic        cfg_big_end = 1'b0;
  logic [35:0] fifo_rd_data = '0;
  logic        fifo_rd_valid = 1'b0;
  logic        fifo_rd_ready;
  logic [35:0] port_out_data;
  logic        port_out_valid;
  logic        port_out_ready = 1'b0;
  logic [35:0] port_in_data = '0;
  logic        port_in_valid = 1'b0;
  logic        port_in_ready;
  logic [35:0] fifo_wr_data;
  logic        fifo_wr_valid;
  logic        fifo_wr_ready = 1'b0;

  always #5 clk = ~clk;

  busmatch_port dut (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [35:0] src_words[$];
  logic [35:0] exp_out[$];
  logic [35:0] in_parts[$];
  logic [35:0] exp_in[$];
  int          cur_m;
  bit          cur_be;
  int          n_out, n_in_acc, n_push;
  bit          st_o, st_w;
  logic [35:0] st_od, st_wd;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nparts(int m);
    return (m == 1) ? 2 : (m == 2) ? 4 : 1;
  endfunction

  function automatic string mtag(int m);
    return (m == 1) ? "R3" : (m == 2) ? "R4" : "R2";
  endfunction

  // Expected port transfer k of word w
  function automatic logic [35:0] part_of(logic [35:0] w, int m, bit be, int k);
    int n;
    int idx;
    n = nparts(m);
    idx = be ? n - 1 - k : k;
    case (m)
      1:       return {18'd0, w[idx*18 +: 18]};
      2:       return {27'd0, w[idx*9 +: 9]};
      default: return w;
    endcase
  endfunction

  function automatic logic [35:0] upper_mask(int m);
    return (m == 1) ? 36'hFFFFC0000 : (m == 2) ? 36'hFFFFFFE00 : 36'h0;
  endfunction

  function automatic logic [35:0] rnd36();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[35:0];
  endfunction

  task automatic master_reset(int code, bit be);
    @(negedge clk);
    rst_n = 1'b0; part_rst = 1'b0;
    cfg_size = code[1:0]; cfg_big_end = be;
    fifo_rd_valid = 0; port_out_ready = 0; port_in_valid = 0; fifo_wr_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: pins change after reset; block must keep the sampled values
    cfg_size = code[1:0] ^ 2'b01;
    cfg_big_end = ~be;
    cur_m = (code == 3) ? 0 : code;
    cur_be = be;
    n_out = 0; n_in_acc = 0; n_push = 0; st_o = 0; st_w = 0;
    #1;
    chk(!port_out_valid && !fifo_wr_valid && fifo_rd_ready && port_in_ready,
        "reset state", {32'd0, port_out_valid, fifo_wr_valid, fifo_rd_ready, port_in_ready},
        36'h3);
  endtask

  // One cycle: drive at negedge, evaluate the upcoming edge's handshakes
  task automatic step(bit fast, string tag);
    bit out_hs, pop, in_hs, push;
    int n;
    n = nparts(cur_m);
    @(negedge clk);
    fifo_rd_valid  = (src_words.size() > 0) && (fast || ($urandom % 4 != 0));
    fifo_rd_data   = (src_words.size() > 0) ? src_words[0] : rnd36();
    port_out_ready = fast || ($urandom % 3 != 0);
    port_in_valid  = (in_parts.size() > 0) && (fast || ($urandom % 4 != 0));
    port_in_data   = (in_parts.size() > 0) ? in_parts[0] : rnd36();
    fifo_wr_ready  = fast || ($urandom % 3 != 0);
    #1;
    if (st_o) chk(port_out_valid && port_out_data == st_od, "R8 port out hold", port_out_data, st_od);
    if (st_w) chk(fifo_wr_valid && fifo_wr_data == st_wd, "R8 fifo write hold", fifo_wr_data, st_wd);
    out_hs = port_out_valid && port_out_ready;
    pop    = fifo_rd_valid && fifo_rd_ready;
    in_hs  = port_in_valid && port_in_ready;
    push   = fifo_wr_valid && fifo_wr_ready;
    if (pop)
      chk(exp_out.size() - (out_hs ? 1 : 0) == 0, "R6 pop with portions pending",
          36'(exp_out.size()), 36'(out_hs ? 1 : 0));
    if (out_hs) begin
      if (exp_out.size() == 0) chk(1'b0, {tag, " unexpected port output"}, port_out_data, 36'h0);
      else begin
        chk(port_out_data == exp_out[0], tag, port_out_data, exp_out[0]);
        if (cur_m != 0)
          chk((port_out_data & upper_mask(cur_m)) == 0, "R5 upper output bits", port_out_data, exp_out[0]);
        void'(exp_out.pop_front());
      end
      n_out++;
    end
    if (pop) begin
      for (int k = 0; k < n; k++) exp_out.push_back(part_of(src_words[0], cur_m, cur_be, k));
      void'(src_words.pop_front());
    end
    if (push) begin
      chk((n_push + 1) * n <= n_in_acc, "R7 push before last portion", 36'(n_in_acc), 36'((n_push + 1) * n));
      if (exp_in.size() == 0) chk(1'b0, {tag, " unexpected push"}, fifo_wr_data, 36'h0);
      else begin
        chk(fifo_wr_data == exp_in[0], {tag, " R5 packed word"}, fifo_wr_data, exp_in[0]);
        void'(exp_in.pop_front());
      end
      n_push++;
    end
    if (in_hs) begin
      void'(in_parts.pop_front());
      n_in_acc++;
    end
    st_o = port_out_valid && !port_out_ready;  st_od = port_out_data;
    st_w = fifo_wr_valid && !fifo_wr_ready;    st_wd = fifo_wr_data;
  endtask

  task automatic queue_words(int nw);
    logic [35:0] w;
    for (int i = 0; i < nw; i++) begin
      src_words.push_back(rnd36());
      w = rnd36();
      exp_in.push_back(w);
      for (int k = 0; k < nparts(cur_m); k++)
        in_parts.push_back(part_of(w, cur_m, cur_be, k) | (rnd36() & upper_mask(cur_m)));
    end
  endtask

  task automatic run_cfg(int code, bit be, int nw, bit fast);
    int t0;
    int lim;
    master_reset(code, be);
    queue_words(nw);
    t0 = cyc;
    lim = 0;
    while ((src_words.size() || exp_out.size() || exp_in.size()) && lim < 20000) begin
      step(fast, mtag(cur_m));
      lim++;
    end
    // R1: transfer count follows the sampled width, not the changed pins
    chk(n_out == nw * nparts(cur_m) && n_push == nw, "R1 transfer count",
        36'(n_out), 36'(nw * nparts(cur_m)));
    if (fast)
      chk(cyc - t0 <= nw * nparts(cur_m) + 4, "R6 gap-free stream cycles",
          36'(cyc - t0), 36'(nw * nparts(cur_m) + 4));
  endtask

  task automatic partial_reset_test();
    logic [35:0] x, y, w;
    int lim;
    master_reset(2, 1'b1);
    // Inbound: two stray bytes, then partial reset, then a full word
    in_parts.push_back(36'h0AA);
    in_parts.push_back(36'h055);
    while (in_parts.size()) step(1'b1, "R9");
    @(negedge clk); part_rst = 1'b1; port_in_valid = 1'b1; fifo_rd_valid = 1'b1;
    #1 chk(!port_in_ready && !fifo_rd_ready && !fifo_wr_valid && !port_out_valid,
           "R9 handshakes blocked", {32'd0, port_in_ready, fifo_rd_ready, fifo_wr_valid, port_out_valid}, 36'h0);
    @(negedge clk); part_rst = 1'b0; fifo_rd_valid = 1'b0; port_in_valid = 1'b0;
    w = rnd36();
    exp_in.push_back(w);
    for (int k = 0; k < 4; k++) in_parts.push_back(part_of(w, 2, 1'b1, k));
    n_in_acc = 0; n_push = 0;
    lim = 0;
    while (exp_in.size() && lim < 200) begin step(1'b0, "R9 inbound after flush"); lim++; end
    chk(exp_in.size() == 0, "R9 inbound word", 36'(exp_in.size()), 36'h0);
    // Outbound: take one byte of x, partial reset, then y must start fresh
    x = rnd36(); y = rnd36();
    @(negedge clk); fifo_rd_data = x; fifo_rd_valid = 1'b1; port_out_ready = 1'b0;
    @(negedge clk); fifo_rd_valid = 1'b0; port_out_ready = 1'b1;
    #1 chk(port_out_valid && port_out_data == {27'd0, x[35:27]}, "R4 first byte big-endian",
           port_out_data, {27'd0, x[35:27]});
    @(negedge clk); port_out_ready = 1'b0; part_rst = 1'b1;
    @(negedge clk); part_rst = 1'b0;
    #1 chk(!port_out_valid && fifo_rd_ready, "R9 outbound cleared",
           {34'd0, port_out_valid, fifo_rd_ready}, 36'h1);
    src_words.push_back(y);
    st_o = 0; st_w = 0; n_out = 0;
    lim = 0;
    while ((src_words.size() || exp_out.size()) && lim < 200) begin step(1'b0, "R9 outbound after flush"); lim++; end
    chk(n_out == 4, "R9 width kept after flush", 36'(n_out), 36'd4);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_cfg(0, 1'b0, 40, 1'b0);
    run_cfg(1, 1'b1, 40, 1'b0);
    run_cfg(1, 1'b0, 40, 1'b0);
    run_cfg(2, 1'b1, 40, 1'b0);
    run_cfg(2, 1'b0, 40, 1'b0);
    run_cfg(3, 1'b1, 20, 1'b0);
    run_cfg(0, 1'b0, 16, 1'b1);
    run_cfg(1, 1'b1, 16, 1'b1);
    run_cfg(2, 1'b0, 16, 1'b1);
    partial_reset_test();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule